// File: doc/BRIEF.md
# Single-Pulse Request Scratchpad Target

This block is a small memory-mapped target that sits on a simple CPU-side bus. A requester starts each transfer by raising a strobe for exactly one clock cycle; in that same cycle it presents the address, write data, byte enables, direction and a few attribute bits. The target answers every accepted transfer with exactly one single-cycle pulse, either an acknowledge or an error.

Inside the target is a word-addressed scratch memory that is cleared by reset and written one byte lane at a time under the byte enables. Legal accesses are acknowledged in the cycle right after the strobe. An access is refused with an error, delivered after a parameterised latency, when it falls outside the target's address window, carries the atomic flag, or reaches the protected upper half of the memory while protection is enabled and the requester is neither privileged nor in debug mode. A strobe that arrives while an error is still counting down breaks the protocol. It is dropped and recorded on a sticky flag.

Top module: `strobe_bus_target`

## Requirements
- R1: After reset, acknowledge, error and the violation flag are low, read data is zero, and every memory word reads as zero.
- R2: A legal access (inside the window, atomic flag low, not blocked) gets exactly one acknowledge pulse in the cycle after its strobe, and no error.
- R3: A legal write (direction bit 1) updates byte lane i, bits 8i+7..8i of the addressed word, only when byte-enable bit i is set. The other lanes keep their value.
- R4: A legal read (direction bit 0) returns the stored word in the acknowledge cycle, and read data is zero in every cycle where acknowledge is low.
- R5: The window is WORDS words at BASE_ADDR, and the word index is address bits 2 and up. An address outside the window gets exactly one error pulse ERR_LAT cycles after the strobe (default 3), no acknowledge, and writes nothing.
- R6: When the protection input is 1, an access to a word whose index MSB is 1 (the upper half) with privilege bit 0 and debug bit 0 is refused as in R5. With the privilege bit or the debug bit set, or with protection 0, the access is legal.
- R7: A request with the atomic flag set is refused as in R5 whatever its 4-bit operation type is, and it writes nothing.
- R8: Privilege, debug, atomic and address inputs are looked at only in the strobe cycle. The fence pulse and the source bit have no effect on responses or memory.
- R9: A strobe in a cycle where a refused access is still waiting and its error is not being delivered in that cycle sets the sticky violation output. That strobe gets no response and writes nothing. A strobe in the same cycle as an error pulse is a normal access.
- R10: Acknowledge and error are never high in the same cycle. If both were due, error takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_stb | input | 1 | One-cycle transfer strobe |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ben | input | 4 | Byte-lane enables |
| req_rw | input | 1 | 0 read, 1 write |
| req_src | input | 1 | 1 instruction fetch, 0 data access |
| req_priv | input | 1 | Privileged requester |
| req_dbg | input | 1 | Requester in debug mode |
| req_amo | input | 1 | Atomic operation flag |
| req_amo_op | input | 4 | Atomic operation type |
| req_fence | input | 1 | Fence pulse, out of band |
| cfg_protect | input | 1 | Restrict upper half to privileged or debug |
| rsp_rdata | output | 32 | Read data, zero unless acknowledge |
| rsp_ack | output | 1 | Acknowledge pulse |
| rsp_err | output | 1 | Error pulse |
| proto_viol | output | 1 | Sticky protocol-violation flag |

## Verification
Two events can fall in the same cycle: a delayed error pulse going out and a new strobe being accepted. The bench places a legal write exactly in the cycle the error of a refused access fires, and expects the error there, the acknowledge one cycle later and the write stored, with no new violation. Just before that it places a strobe one cycle after a refused one, and expects it to be dropped, the flag to latch and only the single error pulse to appear. A fence pulse that comes together with a strobe is also driven, and the bench expects the normal response.

// File: rtl/strobe_tgt_pkg.sv
// Shared types for the strobe bus target.
package strobe_tgt_pkg;

    // Outcome of decoding one strobed request.
    typedef enum logic [1:0] {
        VERDICT_OK     = 2'd0,
        VERDICT_RANGE  = 2'd1,
        VERDICT_PRIV   = 2'd2,
        VERDICT_ATOMIC = 2'd3
    } verdict_e;

endpackage

// File: rtl/strobe_req_decode.sv
// Request decoder: classifies a request as legal or refused and extracts the
// word index. Purely combinational; assumes BASE_ADDR is aligned to the
// window size (WORDS * 4 bytes) and WORDS is a power of two of at least 2.
module strobe_req_decode
    import strobe_tgt_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WORDS     = 16,
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    localparam int         IDX_W     = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv,
    input  logic              dbg,
    input  logic              amo,
    input  logic              protect,
    output logic [IDX_W-1:0]  idx,
    output verdict_e          verdict
);

    localparam int TAG_LO = IDX_W + 2;

    logic in_window;
    logic blocked;

    // Window match, upper-half protection and final verdict.
    always_comb begin
        idx       = addr[TAG_LO-1:2];
        in_window = (addr[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);
        blocked   = protect && idx[IDX_W-1] && !priv && !dbg;
        if (!in_window)   verdict = VERDICT_RANGE;
        else if (amo)     verdict = VERDICT_ATOMIC;
        else if (blocked) verdict = VERDICT_PRIV;
        else              verdict = VERDICT_OK;
    end

endmodule

// File: rtl/strobe_scratch_mem.sv
// Scratch memory: WORDS words of LANES byte lanes, cleared by reset. Each
// lane is its own array so that byte-enabled writes need no read-modify-write.
// The read port is combinational on the index.
module strobe_scratch_mem #(
    parameter int WORDS = 16,
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LANES-1:0]  ben,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_q [WORDS];

        // Store one byte lane: clear on reset, write when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) lane_q[w] <= '0;
            end else if (we && ben[l]) begin
                lane_q[idx] <= wdata[8*l +: 8];
            end
        end

        assign rdata[8*l +: 8] = lane_q[idx];
    end

endmodule

// File: rtl/strobe_err_timer.sv
// Error-latency timer: once loaded, fires one pulse ERR_LAT cycles after the
// load cycle. Busy while a pulse is still owed in a later cycle. Assumes
// ERR_LAT >= 1 and that the caller never loads while busy.
module strobe_err_timer #(
    parameter int ERR_LAT = 3,
    localparam int CNT_W = $clog2(ERR_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic fire,
    output logic busy
);

    logic [CNT_W-1:0] cnt_q;

    // Countdown: load with the latency, step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= CNT_W'(ERR_LAT);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign fire = (cnt_q == CNT_W'(1));
    assign busy = (cnt_q > CNT_W'(1));

endmodule

// File: rtl/strobe_bus_target.sv
// Strobe bus target: accepts one-cycle strobed requests, acknowledges legal
// accesses in the next cycle and refuses the rest with a delayed error pulse.
// Assumes the requester waits for a response before its next strobe; a strobe
// that breaks this while an error is owed is dropped and flagged.
module strobe_bus_target
    import strobe_tgt_pkg::*;
#(
    parameter int          WORDS     = 16,
    parameter int          ERR_LAT   = 3,
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_stb,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_ben,
    input  logic        req_rw,
    input  logic        req_src,
    input  logic        req_priv,
    input  logic        req_dbg,
    input  logic        req_amo,
    input  logic [3:0]  req_amo_op,
    input  logic        req_fence,
    input  logic        cfg_protect,
    output logic [31:0] rsp_rdata,
    output logic        rsp_ack,
    output logic        rsp_err,
    output logic        proto_viol
);

    localparam int IDX_W  = $clog2(WORDS);
    localparam int LANES  = 4;
    localparam int DATA_W = LANES * 8;

    logic [IDX_W-1:0]  idx;
    verdict_e          verdict;
    logic              busy;
    logic              fire;
    logic              accept;
    logic              good;
    logic              refuse;
    logic [DATA_W-1:0] mem_rd;
    logic              ack_q;
    logic [DATA_W-1:0] rdata_q;
    logic              viol_q;
    logic              unused_ok;

    // Source, fence and atomic type never influence the response.
    assign unused_ok = ^{req_src, req_fence, req_amo_op};

    strobe_req_decode #(
        .ADDR_W    (32),
        .WORDS     (WORDS),
        .BASE_ADDR (BASE_ADDR)
    ) i_decode (
        .addr    (req_addr),
        .priv    (req_priv),
        .dbg     (req_dbg),
        .amo     (req_amo),
        .protect (cfg_protect),
        .idx     (idx),
        .verdict (verdict)
    );

    // Strobes are taken only when no error is owed in a later cycle.
    always_comb begin
        accept = req_stb && !busy;
        good   = accept && (verdict == VERDICT_OK);
        refuse = accept && (verdict != VERDICT_OK);
    end

    strobe_scratch_mem #(
        .WORDS (WORDS),
        .LANES (LANES)
    ) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (good && req_rw),
        .ben   (req_ben),
        .idx   (idx),
        .wdata (req_wdata),
        .rdata (mem_rd)
    );

    strobe_err_timer #(
        .ERR_LAT (ERR_LAT)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (refuse),
        .fire  (fire),
        .busy  (busy)
    );

    // Acknowledge stage: one-cycle pulse and captured read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= good;
            rdata_q <= (good && !req_rw) ? mem_rd : '0;
        end
    end

    // Sticky record of a strobe arriving while an error is owed.
    always_ff @(posedge clk) begin
        if (!rst_n)              viol_q <= 1'b0;
        else if (req_stb && busy) viol_q <= 1'b1;
    end

    // Response outputs: error wins, data gated by acknowledge.
    always_comb begin
        rsp_err    = fire;
        rsp_ack    = ack_q && !fire;
        rsp_rdata  = rsp_ack ? rdata_q : '0;
        proto_viol = viol_q;
    end

endmodule

// File: rtl/strobe_bus_target_chk.sv
// Protocol checker for strobe_bus_target, attached by bind. Observes ports only.
module strobe_bus_target_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_stb,
    input logic [31:0] rsp_rdata,
    input logic        rsp_ack,
    input logic        rsp_err,
    input logic        proto_viol
);

    p_excl_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ack && rsp_err));

    p_ack_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> $past(req_stb));

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ack && !req_stb) |=> !rsp_ack);

    p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ack |-> (rsp_rdata == 32'h0));

    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_viol |=> proto_viol);

endmodule

bind strobe_bus_target strobe_bus_target_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_stb    (req_stb),
    .rsp_rdata  (rsp_rdata),
    .rsp_ack    (rsp_ack),
    .rsp_err    (rsp_err),
    .proto_viol (proto_viol)
);

// File: tb/test_strobe_bus_target.sv
// Self-checking bench for strobe_bus_target with default parameters.
module test_strobe_bus_target;

    localparam int          WORDS = 16;
    localparam int          LAT   = 3;
    localparam logic [31:0] BASE  = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_stb = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_ben = '0;
    logic        req_rw = 1'b0;
    logic        req_src = 1'b0;
    logic        req_priv = 1'b0;
    logic        req_dbg = 1'b0;
    logic        req_amo = 1'b0;
    logic [3:0]  req_amo_op = '0;
    logic        req_fence = 1'b0;
    logic        cfg_protect = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_ack;
    logic        rsp_err;
    logic        proto_viol;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [WORDS];

    always #4 clk = ~clk;

    strobe_bus_target i_strobe_bus_target (
        .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ben(req_ben), .req_rw(req_rw),
        .req_src(req_src), .req_priv(req_priv), .req_dbg(req_dbg),
        .req_amo(req_amo), .req_amo_op(req_amo_op), .req_fence(req_fence),
        .cfg_protect(cfg_protect), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
        .rsp_err(rsp_err), .proto_viol(proto_viol)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] waddr(input int w);
        return BASE + 32'(w * 4);
    endfunction

    // One transfer; watches 8 cycles after the strobe and reports the result.
    task automatic xfer(input logic rw, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input logic pv, input logic dg,
                        input logic am, input logic [3:0] op,
                        output int lat, output int npulse, output logic was_err,
                        output logic [31:0] rd, output bit quiet_ok);
        @(negedge clk);
        req_stb = 1'b1; req_rw = rw; req_addr = a; req_wdata = wd; req_ben = be;
        req_priv = pv; req_dbg = dg; req_amo = am; req_amo_op = op;
        req_src = wd[1]; req_fence = wd[0];
        @(negedge clk);
        req_stb = 1'b0; req_fence = 1'b0;
        req_priv = ~pv; req_dbg = ~dg; req_amo = ~am; req_addr = ~a; req_rw = ~rw;
        lat = 0; npulse = 0; was_err = 1'b0; rd = '0; quiet_ok = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            if (rsp_ack && rsp_err) quiet_ok = 1'b0;
            if (!rsp_ack && rsp_rdata != 32'h0) quiet_ok = 1'b0;
            if (rsp_ack || rsp_err) begin
                if (npulse == 0) begin
                    lat = k; was_err = rsp_err; rd = rsp_rdata;
                end
                npulse++;
            end
            @(negedge clk);
        end
        req_priv = 1'b0; req_dbg = 1'b0; req_amo = 1'b0;
    endtask

    // Write with full attribute control and check response against expectation.
    task automatic wr_chk(input int w_or_neg, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input logic pv, input logic dg,
                          input logic am, input bit legal, input string req);
        int lat, np; logic e; logic [31:0] rd; bit q;
        xfer(1'b1, a, wd, be, pv, dg, am, wd[7:4], lat, np, e, rd, q);
        if (legal) begin
            chk(lat == 1 && np == 1 && !e && q, req, 32'(lat * 16 + np), 32'h11);
            if (w_or_neg >= 0)
                for (int l = 0; l < 4; l++)
                    if (be[l]) model[w_or_neg][8*l +: 8] = wd[8*l +: 8];
        end else begin
            chk(lat == LAT && np == 1 && e && q, req, 32'(lat * 16 + np), 32'(LAT * 16 + 1));
        end
    endtask

    task automatic rd_chk(input int w, input string req);
        int lat, np; logic e; logic [31:0] rd; bit q;
        xfer(1'b0, waddr(w), 32'h0, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0, lat, np, e, rd, q);
        chk(lat == 1 && np == 1 && !e && q && rd == model[w], req, rd, model[w]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < WORDS; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and cleared memory
        chk(!rsp_ack && !rsp_err && !proto_viol && rsp_rdata == 0, "R1 reset outputs",
            {rsp_rdata[28:0], rsp_ack, rsp_err, proto_viol}, 32'h0);
        for (int w = 0; w < WORDS; w++) rd_chk(w, "R1 cleared word");

        // R3/R2: every byte-enable pattern on one word, read back each time
        for (int b = 0; b < 16; b++) begin
            wr_chk(5, waddr(5), 32'h1122_3344 ^ (32'h0101_0101 * b), 4'(b),
                   1'b0, 1'b0, 1'b0, 1'b1, "R3 byte-enabled write ack");
            rd_chk(5, "R3 lane merge");
        end

        // R4: full-word write and read of every word
        for (int w = 0; w < WORDS; w++)
            wr_chk(w, waddr(w), 32'hC3C3_0000 ^ (32'h1000_0001 * w), 4'hF,
                   1'b1, 1'b0, 1'b0, 1'b1, "R4 word write");
        for (int w = 0; w < WORDS; w++) rd_chk(w, "R4 word read");

        // R5: addresses outside the window
        wr_chk(-1, BASE - 4, 32'hDEAD_0001, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, "R5 below window");
        wr_chk(-1, BASE + 64, 32'hDEAD_0002, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, "R5 above window");
        wr_chk(-1, 32'h0, 32'hDEAD_0003, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, "R5 zero address");
        wr_chk(-1, 32'hFFFF_FFFC, 32'hDEAD_0004, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, "R5 top address");
        rd_chk(0, "R5 no write through alias");
        rd_chk(15, "R5 no write at edge");

        // R6: protection, privilege and debug over every word
        for (int c = 0; c < 8; c++) begin
            cfg_protect = c[2];
            for (int w = 0; w < WORDS; w++)
                wr_chk((c[2] && w >= 8 && !c[1] && !c[0]) ? -1 : w, waddr(w),
                       32'h6000_0000 + 32'(c * 256 + w), 4'hF, c[1], c[0], 1'b0,
                       !(c[2] && w >= 8 && !c[1] && !c[0]), "R6 protection");
            for (int w = 0; w < WORDS; w++) rd_chk(w, "R6 contents");
        end

        // R7: atomic flag refused for every operation type
        cfg_protect = 1'b0;
        for (int op = 0; op < 16; op++)
            wr_chk(-1, waddr(3), {24'hA70000, 4'(op), 4'h0}, 4'hF, 1'b1, 1'b0, 1'b1,
                   1'b0, "R7 atomic refused");
        rd_chk(3, "R7 atomic wrote nothing");

        // R8: attributes outside the strobe cycle; fence alone
        cfg_protect = 1'b1;
        @(negedge clk); req_priv = 1'b1; req_dbg = 1'b1;
        wr_chk(-1, waddr(12), 32'h0000_0000, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0,
               "R8 attributes before strobe ignored");
        rd_chk(12, "R8 blocked write absent");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); req_fence = k[0];
            chk(!rsp_ack && !rsp_err, "R8 fence no response", {rsp_ack, rsp_err}, 32'h0);
        end
        req_fence = 1'b0;
        cfg_protect = 1'b0;
        chk(!proto_viol, "R9 flag low before violation", proto_viol, 32'h0);

        // R9: strobe one cycle after a refused one is dropped and flagged
        @(negedge clk);
        req_stb = 1'b1; req_rw = 1'b1; req_addr = 32'h0; req_ben = 4'hF;
        req_wdata = 32'hBAD0_0000;
        @(negedge clk);
        req_addr = waddr(2); req_wdata = 32'h5555_AAAA;
        @(negedge clk);
        req_stb = 1'b0;
        chk(proto_viol && !rsp_ack && !rsp_err, "R9 flag set, no response",
            {proto_viol, rsp_ack, rsp_err}, 32'h4);
        @(negedge clk);
        chk(rsp_err && !rsp_ack, "R9 single error at latency", {rsp_ack, rsp_err}, 32'h1);
        @(negedge clk);
        chk(!rsp_err && !rsp_ack, "R9 dropped strobe silent", {rsp_ack, rsp_err}, 32'h0);
        rd_chk(2, "R9 dropped write absent");

        // R9/R10: strobe in the error cycle is accepted
        @(negedge clk);
        req_stb = 1'b1; req_rw = 1'b1; req_addr = 32'h0; req_ben = 4'hF;
        @(negedge clk); req_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(rsp_err && !rsp_ack, "R10 error pulse at overlap", {rsp_ack, rsp_err}, 32'h1);
        req_stb = 1'b1; req_addr = waddr(4); req_wdata = 32'h7777_1234;
        @(negedge clk);
        req_stb = 1'b0;
        chk(rsp_ack && !rsp_err, "R9 strobe in error cycle acknowledged",
            {rsp_ack, rsp_err}, 32'h2);
        model[4] = 32'h7777_1234;
        @(negedge clk);
        chk(!rsp_ack && !rsp_err, "R10 single pulse after overlap", {rsp_ack, rsp_err}, 32'h0);
        rd_chk(4, "R9 overlap write stored");
        chk(proto_viol, "R9 flag sticky", proto_viol, 32'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule